// File: doc/BRIEF.md
# Border-Aligned Hit Window Gatherer

This block collects the one-bit-per-cell hit map of an 8x8 detector board and the bits from its neighbouring boards that a 2x2 cluster search needs at the board's top and right edges. Three border sources feed it: an 8-bit row from the board above, an 8-bit column from the board to the right, and one bit from the diagonal board. Each source reaches the block after a different transport latency. The block therefore passes the local map and each border source through its own delay pipeline. Each pipeline has a 4-bit code that selects 0 to 15 extra clocks, so that all bits that reach the assembly stage belong to the same bunch crossing.

After alignment the block builds a 9x9 extended map. Row 8 holds the upper border and column 8 holds the right border. A per-source enable mask forces absent neighbours to zero at the detector edge. A one-bit half select then picks the 45 bits that one downstream half-board consumes: four local columns, the column to their right, and the row above them. The result is registered. One copy of the block is instantiated for each hit map type, so the same structure serves both the pad-detector map and the preshower map.

Top module: `hit_border_gather`

## Requirements
- R1: While `rstN` is low, `winOut` is zero and every delay stage is cleared. Data presented before reset release never reaches the output.
- R2: A local map bit presented in cycle n appears at the output in cycle n+`dlyLocal`+1, for every code from 0 to 15. Local cell (row r, column c) is `localMap[r*8+c]`.
- R3: Upper border bit `northRow[c]` is cell (row 8, column c). It reaches the output `dlyNorth`+1 cycles after it is presented.
- R4: Right border bit `eastCol[r]` is cell (row r, column 8). It reaches the output `dlyEast`+1 cycles after it is presented, and it is visible only when `outAddr` is 1.
- R5: `cornerBit` is cell (row 8, column 8). It reaches the output `dlyCorner`+1 cycles after it is presented, at `winOut[44]`, and only when `outAddr` is 1.
- R6: With `outAddr` = 0, `winOut[r*5+k]` carries cell (row r, column k) for r from 0 to 8 and k from 0 to 4. The fifth column is local column 4.
- R7: With `outAddr` = 1, `winOut[r*5+k]` carries cell (row r, column 4+k). The fifth column is the right border, and `winOut[44]` is the diagonal bit.
- R8: `edgeMask[0]` enables the upper border, `edgeMask[1]` the right border and `edgeMask[2]` the diagonal bit. When an enable is 0, the output positions that source would fill are 0 one cycle later.
- R9: `outAddr`, `edgeMask` and every delay code act on the output of the next clock edge. Changing a delay code does not flush the pipeline: the output then takes the stage that holds data from the newly selected number of cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| localMap | input | 64 | Local hit map, row-major |
| northRow | input | 8 | Border row from the board above |
| eastCol | input | 8 | Border column from the board to the right |
| cornerBit | input | 1 | Bit from the diagonal board |
| dlyLocal | input | 4 | Extra delay for the local map, in clocks |
| dlyNorth | input | 4 | Extra delay for the upper border |
| dlyEast | input | 4 | Extra delay for the right border |
| dlyCorner | input | 4 | Extra delay for the diagonal bit |
| edgeMask | input | 3 | Border enables: bit 0 upper, bit 1 right, bit 2 diagonal |
| outAddr | input | 1 | Half select: 0 picks columns 0-4, 1 picks columns 4-8 |
| winOut | output | 45 | Registered 9-row by 5-column window |

## Verification
The assertions check on every clock that a disabled border source produces zeros at its output positions, that the output stays zero under reset, and that with a zero delay code the half select routes the correct local and upper-border bits. The full timing behaviour can only be shown by the bench scenarios. That covers alignment at every delay code up to 15, delay codes that change while data is in flight, and the interaction of the three border sources with different codes. The bench compares every output field against a history-based reference over directed and random sequences.

// File: rtl/hitgather_pkg.sv
package hitgather_pkg;
  localparam int ROWS    = 8;
  localparam int COLS    = 8;
  localparam int DLY_W   = 4;
  localparam int MAX_DLY = (1 << DLY_W) - 1;
  localparam int HALF    = COLS / 2;
  localparam int OUT_W   = (ROWS + 1) * (HALF + 1);
  localparam int MAP_W   = ROWS * COLS;

  typedef struct packed {
    logic [MAX_DLY:0] tapLocal;
    logic [MAX_DLY:0] tapNorth;
    logic [MAX_DLY:0] tapEast;
    logic [MAX_DLY:0] tapCorner;
    logic             gateNorth;
    logic             gateEast;
    logic             gateCorner;
    logic             half;
  } ctlStrobe_t;
endpackage

// File: rtl/hitgather_delay.sv
module hitgather_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [W-1:0]     din,
  input  logic [DEPTH:0]   tapHot,
  output logic [W-1:0]     dout
);
  logic [W-1:0] stg [0:DEPTH];

  assign stg[0] = din;

  for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[i] <= '0;
      else       stg[i] <= stg[i-1];
    end
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i <= DEPTH; i++) begin
      dout = dout | (stg[i] & {W{tapHot[i]}});
    end
  end
endmodule

// File: rtl/hitgather_ctrl.sv
module hitgather_ctrl
  import hitgather_pkg::*;
(
  input  logic [DLY_W-1:0] dlyLocal,
  input  logic [DLY_W-1:0] dlyNorth,
  input  logic [DLY_W-1:0] dlyEast,
  input  logic [DLY_W-1:0] dlyCorner,
  input  logic [2:0]       edgeMask,
  input  logic             outAddr,
  output ctlStrobe_t       strobe
);
  function automatic logic [MAX_DLY:0] toHot(input logic [DLY_W-1:0] code);
    logic [MAX_DLY:0] h;
    h = '0;
    h[code] = 1'b1;
    return h;
  endfunction

  always_comb begin
    strobe            = '0;
    strobe.tapLocal   = toHot(dlyLocal);
    strobe.tapNorth   = toHot(dlyNorth);
    strobe.tapEast    = toHot(dlyEast);
    strobe.tapCorner  = toHot(dlyCorner);
    strobe.gateNorth  = edgeMask[0];
    strobe.gateEast   = edgeMask[1];
    strobe.gateCorner = edgeMask[2];
    strobe.half       = outAddr;
  end
endmodule

// File: rtl/hitgather_datapath.sv
module hitgather_datapath
  import hitgather_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [MAP_W-1:0] localMap,
  input  logic [COLS-1:0]  northRow,
  input  logic [ROWS-1:0]  eastCol,
  input  logic             cornerBit,
  input  ctlStrobe_t       strobe,
  output logic [OUT_W-1:0] winOut
);
  logic [MAP_W-1:0] locD;
  logic [COLS-1:0]  northD;
  logic [ROWS-1:0]  eastD;
  logic [0:0]       cornerD;
  logic [ROWS:0][COLS:0] ext;
  logic [OUT_W-1:0] winNext;

  hitgather_delay #(.W(MAP_W), .DEPTH(MAX_DLY)) u_dlyLocal (
    .clk(clk), .rstN(rstN), .din(localMap), .tapHot(strobe.tapLocal), .dout(locD));
  hitgather_delay #(.W(COLS), .DEPTH(MAX_DLY)) u_dlyNorth (
    .clk(clk), .rstN(rstN), .din(northRow), .tapHot(strobe.tapNorth), .dout(northD));
  hitgather_delay #(.W(ROWS), .DEPTH(MAX_DLY)) u_dlyEast (
    .clk(clk), .rstN(rstN), .din(eastCol), .tapHot(strobe.tapEast), .dout(eastD));
  hitgather_delay #(.W(1), .DEPTH(MAX_DLY)) u_dlyCorner (
    .clk(clk), .rstN(rstN), .din(cornerBit), .tapHot(strobe.tapCorner), .dout(cornerD));

  // Extended map: row ROWS is the upper border, column COLS the right border.
  always_comb begin
    ext = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        ext[r][c] = locD[r*COLS + c];
      end
      ext[r][COLS] = eastD[r] & strobe.gateEast;
    end
    for (int c = 0; c < COLS; c++) begin
      ext[ROWS][c] = northD[c] & strobe.gateNorth;
    end
    ext[ROWS][COLS] = cornerD[0] & strobe.gateCorner;
  end

  // Half selection: HALF local columns plus one column to their right.
  always_comb begin
    winNext = '0;
    for (int r = 0; r <= ROWS; r++) begin
      for (int k = 0; k <= HALF; k++) begin
        if (strobe.half) winNext[r*(HALF+1) + k] = ext[r][HALF + k];
        else             winNext[r*(HALF+1) + k] = ext[r][k];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) winOut <= '0;
    else       winOut <= winNext;
  end
endmodule

// File: rtl/hit_border_gather.sv
module hit_border_gather
  import hitgather_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] localMap,
  input  logic [7:0]  northRow,
  input  logic [7:0]  eastCol,
  input  logic        cornerBit,
  input  logic [3:0]  dlyLocal,
  input  logic [3:0]  dlyNorth,
  input  logic [3:0]  dlyEast,
  input  logic [3:0]  dlyCorner,
  input  logic [2:0]  edgeMask,
  input  logic        outAddr,
  output logic [44:0] winOut
);
  ctlStrobe_t strobe;

  hitgather_ctrl u_ctrl (
    .dlyLocal(dlyLocal), .dlyNorth(dlyNorth), .dlyEast(dlyEast),
    .dlyCorner(dlyCorner), .edgeMask(edgeMask), .outAddr(outAddr),
    .strobe(strobe));

  hitgather_datapath u_dp (
    .clk(clk), .rstN(rstN), .localMap(localMap), .northRow(northRow),
    .eastCol(eastCol), .cornerBit(cornerBit), .strobe(strobe),
    .winOut(winOut));
endmodule

// File: rtl/hit_border_gather_chk.sv
module hit_border_gather_chk (
  input logic        clk,
  input logic        rstN,
  input logic [63:0] localMap,
  input logic [7:0]  northRow,
  input logic [3:0]  dlyLocal,
  input logic [3:0]  dlyNorth,
  input logic [2:0]  edgeMask,
  input logic        outAddr,
  input logic [44:0] winOut
);
  function automatic logic [44:0] eastPos();
    logic [44:0] m;
    m = '0;
    for (int r = 0; r < 8; r++) m[r*5 + 4] = 1'b1;
    return m;
  endfunction
  localparam logic [44:0] EAST_POS = eastPos();

  // R1: output held at zero under reset
  always @(negedge clk) begin
    if (!rstN) p_reset_zero_r1: assert (winOut == '0);
  end

  p_mask_north_r8: assert property (@(posedge clk) disable iff (!rstN)
    !edgeMask[0] |=> winOut[43:40] == 4'b0);
  p_mask_east_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!edgeMask[1] && outAddr) |=> (winOut & EAST_POS) == '0);
  p_mask_corner_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!edgeMask[2] && outAddr) |=> !winOut[44]);
  p_local_nodelay_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dlyLocal == 4'd0 && !outAddr) |=> winOut[0] == $past(localMap[0]));
  p_half0_col4_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dlyLocal == 4'd0 && !outAddr) |=> winOut[4] == $past(localMap[4]));
  p_half1_col0_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dlyLocal == 4'd0 && outAddr) |=> winOut[0] == $past(localMap[4]));
  p_north_nodelay_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dlyNorth == 4'd0 && edgeMask[0]) |=>
      winOut[40] == $past(outAddr ? northRow[4] : northRow[0]));
endmodule

bind hit_border_gather hit_border_gather_chk u_chk (
  .clk(clk), .rstN(rstN), .localMap(localMap), .northRow(northRow),
  .dlyLocal(dlyLocal), .dlyNorth(dlyNorth), .edgeMask(edgeMask),
  .outAddr(outAddr), .winOut(winOut));

// File: tb/hit_border_gather_tb.sv
module hit_border_gather_tb;
  localparam int NCYC = 3000;

  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] localMap;
  logic [7:0]  northRow, eastCol;
  logic        cornerBit;
  logic [3:0]  dlyLocal, dlyNorth, dlyEast, dlyCorner;
  logic [2:0]  edgeMask;
  logic        outAddr;
  logic [44:0] winOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string phase = "init";

  logic [63:0] hL [0:NCYC-1];
  logic [7:0]  hN [0:NCYC-1];
  logic [7:0]  hE [0:NCYC-1];
  logic        hC [0:NCYC-1];
  logic [3:0]  hdL [0:NCYC-1];
  logic [3:0]  hdN [0:NCYC-1];
  logic [3:0]  hdE [0:NCYC-1];
  logic [3:0]  hdC [0:NCYC-1];
  logic [2:0]  hM [0:NCYC-1];
  logic        hA [0:NCYC-1];

  always #10 clk = ~clk;

  hit_border_gather u_dut (
    .clk(clk), .rstN(rstN), .localMap(localMap), .northRow(northRow),
    .eastCol(eastCol), .cornerBit(cornerBit), .dlyLocal(dlyLocal),
    .dlyNorth(dlyNorth), .dlyEast(dlyEast), .dlyCorner(dlyCorner),
    .edgeMask(edgeMask), .outAddr(outAddr), .winOut(winOut));

  task automatic chk(input string tag, input logic [44:0] got, input logic [44:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s [%s] cycle %0d got %h expected %h", tag, phase, cyc, got, exp);
    end
  endtask

  // field: 0 local cells, 1 upper border, 2 right border, 3 diagonal
  function automatic logic [44:0] fieldMask(input logic a, input int field);
    logic [44:0] m;
    m = '0;
    for (int r = 0; r <= 8; r++) begin
      for (int k = 0; k <= 4; k++) begin
        int col, f;
        col = k + (a ? 4 : 0);
        if (r < 8 && col < 8)  f = 0;
        else if (r == 8 && col < 8) f = 1;
        else if (r < 8)        f = 2;
        else                   f = 3;
        if (f == field) m[r*5 + k] = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic logic [44:0] expectAt(input int n);
    logic [44:0] e;
    logic [63:0] l;
    logic [7:0]  nr, ec;
    logic        cb;
    logic        a;
    e  = '0;
    a  = hA[n];
    l  = (n - int'(hdL[n]) >= 0) ? hL[n - int'(hdL[n])] : 64'd0;
    nr = (n - int'(hdN[n]) >= 0) ? hN[n - int'(hdN[n])] : 8'd0;
    ec = (n - int'(hdE[n]) >= 0) ? hE[n - int'(hdE[n])] : 8'd0;
    cb = (n - int'(hdC[n]) >= 0) ? hC[n - int'(hdC[n])] : 1'b0;
    for (int r = 0; r <= 8; r++) begin
      for (int k = 0; k <= 4; k++) begin
        int col;
        col = k + (a ? 4 : 0);
        if (r < 8 && col < 8)       e[r*5+k] = l[r*8 + col];
        else if (r == 8 && col < 8) e[r*5+k] = nr[col] & hM[n][0];
        else if (r < 8)             e[r*5+k] = ec[r] & hM[n][1];
        else                        e[r*5+k] = cb & hM[n][2];
      end
    end
    return e;
  endfunction

  // drive the current inputs as cycle cyc, wait one clock, compare fields
  task automatic step();
    logic [44:0] e;
    logic        a;
    hL[cyc] = localMap; hN[cyc] = northRow; hE[cyc] = eastCol; hC[cyc] = cornerBit;
    hdL[cyc] = dlyLocal; hdN[cyc] = dlyNorth; hdE[cyc] = dlyEast; hdC[cyc] = dlyCorner;
    hM[cyc] = edgeMask; hA[cyc] = outAddr;
    @(negedge clk);
    e = expectAt(cyc);
    a = hA[cyc];
    chk(a ? "R2 R7 local" : "R2 R6 local", winOut & fieldMask(a, 0), e & fieldMask(a, 0));
    chk(hM[cyc][0] ? "R3 upper" : "R3 R8 upper", winOut & fieldMask(a, 1), e & fieldMask(a, 1));
    if (a) begin
      chk(hM[cyc][1] ? "R4 right" : "R4 R8 right", winOut & fieldMask(a, 2), e & fieldMask(a, 2));
      chk(hM[cyc][2] ? "R5 diag" : "R5 R8 diag", winOut & fieldMask(a, 3), e & fieldMask(a, 3));
    end
    cyc++;
  endtask

  task automatic randData();
    localMap  = {$urandom, $urandom};
    northRow  = 8'($urandom);
    eastCol   = 8'($urandom);
    cornerBit = 1'($urandom);
  endtask

  task automatic randCfg();
    dlyLocal  = 4'($urandom);
    dlyNorth  = 4'($urandom);
    dlyEast   = 4'($urandom);
    dlyCorner = 4'($urandom);
    edgeMask  = 3'($urandom);
    outAddr   = 1'($urandom);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17C0DE));
    rstN = 1'b0;
    localMap = '1; northRow = '1; eastCol = '1; cornerBit = 1'b1;
    dlyLocal = 4'd0; dlyNorth = 4'd0; dlyEast = 4'd0; dlyCorner = 4'd0;
    edgeMask = 3'b111; outAddr = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reset", winOut, 45'd0);
    localMap = '0; northRow = '0; eastCol = '0; cornerBit = 1'b0;
    rstN = 1'b1;
    // R1: all-ones presented under reset must not appear once released
    phase = "R1 post-reset";
    dlyLocal = 4'd3; dlyNorth = 4'd5; dlyEast = 4'd9; dlyCorner = 4'd15;
    for (int i = 0; i < 4; i++) step();

    // R6 R7: walking bit through every local cell, both halves, no delay
    phase = "R6 R7 walk";
    dlyLocal = 4'd0; dlyNorth = 4'd0; dlyEast = 4'd0; dlyCorner = 4'd0;
    for (int i = 0; i < 64; i++) begin
      localMap = 64'd1 << i;
      northRow = 8'd1 << (i % 8);
      eastCol  = 8'd1 << (i / 8);
      cornerBit = i[0];
      outAddr  = (i % 8) >= 4;
      step();
    end

    // R2 R3 R4 R5: maximum delays with sparse pulses
    phase = "R2 R3 R4 R5 max delay";
    dlyLocal = 4'd15; dlyNorth = 4'd15; dlyEast = 4'd15; dlyCorner = 4'd15;
    outAddr = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (i % 7 == 0) randData();
      else begin localMap = '0; northRow = '0; eastCol = '0; cornerBit = 1'b0; end
      step();
    end

    // R2 R3 R4 R5: distinct delay per source
    phase = "R2 R3 R4 R5 skewed";
    dlyLocal = 4'd2; dlyNorth = 4'd7; dlyEast = 4'd11; dlyCorner = 4'd4;
    for (int i = 0; i < 60; i++) begin
      randData();
      outAddr = i[1];
      step();
    end

    // R9: switch delay codes while data is in flight
    phase = "R9 delay switch";
    dlyLocal = 4'd6; dlyNorth = 4'd6; dlyEast = 4'd6; dlyCorner = 4'd6;
    for (int i = 0; i < 30; i++) begin randData(); step(); end
    dlyLocal = 4'd1; dlyNorth = 4'd12; dlyEast = 4'd0; dlyCorner = 4'd9;
    for (int i = 0; i < 30; i++) begin randData(); outAddr = i[0]; step(); end

    // R8: each enable cleared in turn with all-ones data
    phase = "R8 mask sweep";
    localMap = '1; northRow = '1; eastCol = '1; cornerBit = 1'b1;
    dlyLocal = 4'd0; dlyNorth = 4'd0; dlyEast = 4'd0; dlyCorner = 4'd0;
    for (int i = 0; i < 16; i++) begin
      edgeMask = 3'(i % 8);
      outAddr  = i[3];
      step();
    end
    edgeMask = 3'b111;

    // random traffic with occasional configuration changes
    phase = "random";
    for (int i = 0; i < 2000; i++) begin
      if (i % 17 == 0) randCfg();
      else if (i % 5 == 0) begin
        outAddr  = 1'($urandom);
        edgeMask = 3'($urandom);
      end
      randData();
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule